// File: doc/BRIEF.md
# Word-Packed SPI Byte FIFO Pair

This block sits between a 32-bit host data port and a byte-serial SPI shift engine. It holds two independent byte queues, one per direction, each 32 bytes deep by default. On the transmit side the host writes whole 32-bit words and the block splits each word into bytes that the engine pulls out one at a time. On the receive side the engine pushes single bytes and the host reads them back packed four to a word.

A chunk-length value, loaded at the start of each chunk, sets how many bytes the current chunk carries. The block counts down what remains in each direction. Every host access moves four bytes while at least four remain, and otherwise only the remaining one to three bytes: the unused lanes of a transmit word are discarded, and the unused lanes of a receive word read as zero. A separate byte-order control per direction chooses whether byte 0 of a word sits in the least or the most significant lane. Both queues publish their byte occupancy so the engine can pace itself. A sticky flag reports a dropped host write that did not fit, and another reports a host read that found too few bytes. A synchronous soft reset empties both queues.

Top module: `spi_word_fifo`

## Requirements
- R1: After reset, both occupancy outputs are 0, both sticky flags are 0, and both remaining-byte counts are 0.
- R2: With tx_swap low, a host word yields bytes in the order bits [7:0], [15:8], [23:16], [31:24] on eng_tx_byte, which always shows the oldest stored byte.
- R3: With tx_swap high, the byte order is reversed: bits [31:24] leave first and bits [7:0] leave last.
- R4: chunk_load loads the remaining count from chunk_len, clamped to the queue depth (32). Each host write stores min(4, remaining) bytes and lowers the count by that amount. The lowest-order lanes in byte order are kept and the rest are discarded. A write when the count is 0 stores nothing and sets no flag.
- R5: A host write that needs more bytes than are free stores nothing and leaves occupancy unchanged. It sets tx_ovf, which then stays 1 until soft reset.
- R6: With rx_swap low and at least min(4, remaining) bytes queued, host_rdata (valid in the cycle host_rd is high) holds the oldest byte in bits [7:0], the next in [15:8], and so on. Lanes past the remaining count read as 0. The read removes exactly that many bytes.
- R7: With rx_swap high, the oldest received byte appears in bits [31:24] and the unused lanes are the low-order ones, reading 0.
- R8: A host read with fewer queued bytes than needed, or with a remaining count of 0, returns 0 and removes nothing. It sets rx_udf, which then stays 1 until soft reset.
- R9: soft_rst empties both queues and clears both flags and both remaining counts in the next cycle.
- R10: Occupancy counts bytes and never exceeds 32. An engine pop on an empty TX queue and an engine push into a full RX queue are ignored.
- R11: Byte order is preserved when the storage pointers wrap past the end of the array, including when a single word straddles the wrap point.
- R12: A host write and an engine pop in the same cycle both take effect, and the TX occupancy changes by the stored count minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Synchronous clear of both queues, counts and flags |
| chunk_load | input | 1 | Loads both remaining-byte counts from chunk_len |
| chunk_len | input | 6 | Byte count of the next chunk (clamped to depth) |
| tx_swap | input | 1 | TX byte order: 1 puts byte 0 in bits [31:24] |
| rx_swap | input | 1 | RX byte order: 1 puts byte 0 in bits [31:24] |
| host_wr | input | 1 | Host write strobe for the TX word |
| host_wdata | input | 32 | Host TX word |
| host_rd | input | 1 | Host read strobe for the RX word |
| host_rdata | output | 32 | Packed RX word, valid while host_rd is high |
| eng_tx_pop | input | 1 | Engine takes the TX byte shown on eng_tx_byte |
| eng_tx_byte | output | 8 | Oldest TX byte |
| eng_tx_level | output | 6 | TX bytes queued |
| eng_rx_push | input | 1 | Engine stores eng_rx_byte |
| eng_rx_byte | input | 8 | Received byte from the engine |
| eng_rx_level | output | 6 | RX bytes queued |
| tx_ovf | output | 1 | Sticky: a host write was dropped |
| rx_udf | output | 1 | Sticky: a host read found too few bytes |

## Verification
The assertions assume that every strobe is a synchronous single-cycle request sampled at the rising edge. They also assume that the depth is a power of two no smaller than a word, so that pointer arithmetic wraps cleanly. They take no view on the order in which software loads a chunk and moves words: a load in the same cycle as a write is legal, and the write still uses the old count. The stimulus changes every input only at the falling edge and samples outputs there, with the combinational read word checked while host_rd is held. It reaches the full and empty limits on purpose, including a word that straddles the pointer wrap.

// File: rtl/spwf_pkg.sv
package spwf_pkg;
  // Lanes per host word and bits per lane
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef logic [LANES-1:0][LANE_W-1:0] lane_word_t;
endpackage

// File: rtl/spwf_lane_order.sv
module spwf_lane_order
  import spwf_pkg::*;
(
  input  logic       swap,
  input  lane_word_t din,
  output lane_word_t dout
);
  // Lane k carries byte k when swap is low, byte LANES-1-k when high
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign dout[k] = swap ? din[LANES-1-k] : din[k];
  end
endmodule

// File: rtl/spwf_tx_unpack.sv
module spwf_tx_unpack
  import spwf_pkg::*;
#(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1),
  localparam int unsigned LW    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              load,
  input  logic [CW-1:0]     len,
  input  logic              swap,
  input  logic              wr,
  input  lane_word_t        wdata,
  input  logic              pop,
  output logic [LANE_W-1:0] head,
  output logic [CW-1:0]     level,
  output logic              ovf
);
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d, rem_q, rem_d;
  logic [CW-1:0] need_c, free_c, len_c;
  logic          ovf_q, ovf_d;
  logic          wr_fit, wr_bad, pop_ok, upd;
  lane_word_t    ordered;
  logic [DEPTH-1:0][LANE_W-1:0] slots;

  spwf_lane_order u_order (
    .swap (swap),
    .din  (wdata),
    .dout (ordered)
  );

  // Request decode
  always_comb begin
    len_c  = (len > CW'(DEPTH)) ? CW'(DEPTH) : len;
    need_c = (rem_q >= CW'(LANES)) ? CW'(LANES) : rem_q;
    free_c = CW'(DEPTH) - cnt_q;
    wr_fit = wr && (need_c != '0) && (free_c >= need_c);
    wr_bad = wr && (need_c != '0) && (free_c < need_c);
    pop_ok = pop && (cnt_q != '0);
  end

  // Next state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    rem_d    = rem_q;
    ovf_d    = ovf_q;
    if (soft_rst) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
      rem_d    = '0;
      ovf_d    = 1'b0;
    end else begin
      if (wr_fit) wr_ptr_d = wr_ptr_q + PW'(need_c);
      if (pop_ok) rd_ptr_d = rd_ptr_q + PW'(1);
      cnt_d = cnt_q + (wr_fit ? need_c : '0) - CW'(pop_ok);
      if (load)        rem_d = len_c;
      else if (wr_fit) rem_d = rem_q - need_c;
      ovf_d = ovf_q | wr_bad;
    end
  end

  assign upd = soft_rst | load | wr | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      rem_q    <= '0;
      ovf_q    <= 1'b0;
    end else if (upd) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      rem_q    <= rem_d;
      ovf_q    <= ovf_d;
    end
  end

  // Byte storage: slot j takes lane (j - wr_ptr) when that lane is stored
  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic [PW-1:0]     ofs;
    logic              we;
    logic [LANE_W-1:0] byte_q;
    assign ofs = PW'(j) - wr_ptr_q;
    assign we  = wr_fit && (CW'(ofs) < need_c);
    always_ff @(posedge clk) begin
      if (we) byte_q <= ordered[ofs[LW-1:0]];
    end
    assign slots[j] = byte_q;
  end

  assign head  = slots[rd_ptr_q];
  assign level = cnt_q;
  assign ovf   = ovf_q;

  // R10
  tx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R9
  tx_soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cnt_q == '0) && (rem_q == '0) && !ovf_q);
  // R5
  tx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !soft_rst |=> ovf_q);
  // R5
  tx_drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad && !pop && !soft_rst |=> $stable(cnt_q) && $stable(wr_ptr_q));
  // R10
  tx_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && (cnt_q == '0) && !wr && !soft_rst |=> cnt_q == '0);
endmodule

// File: rtl/spwf_rx_pack.sv
module spwf_rx_pack
  import spwf_pkg::*;
#(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              load,
  input  logic [CW-1:0]     len,
  input  logic              swap,
  input  logic              rd,
  output lane_word_t        rdata,
  input  logic              push,
  input  logic [LANE_W-1:0] din,
  output logic [CW-1:0]     level,
  output logic              udf
);
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d, rem_q, rem_d;
  logic [CW-1:0] need_c, len_c;
  logic          udf_q, udf_d;
  logic          rd_ok, rd_bad, push_ok, upd;
  lane_word_t    raw;
  logic [DEPTH-1:0][LANE_W-1:0] slots;

  // Request decode
  always_comb begin
    len_c   = (len > CW'(DEPTH)) ? CW'(DEPTH) : len;
    need_c  = (rem_q >= CW'(LANES)) ? CW'(LANES) : rem_q;
    push_ok = push && (cnt_q != CW'(DEPTH));
    rd_ok   = rd && (need_c != '0) && (cnt_q >= need_c);
    rd_bad  = rd && !rd_ok;
  end

  // Next state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    rem_d    = rem_q;
    udf_d    = udf_q;
    if (soft_rst) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
      rem_d    = '0;
      udf_d    = 1'b0;
    end else begin
      if (push_ok) wr_ptr_d = wr_ptr_q + PW'(1);
      if (rd_ok)   rd_ptr_d = rd_ptr_q + PW'(need_c);
      cnt_d = cnt_q + CW'(push_ok) - (rd_ok ? need_c : '0);
      if (load)       rem_d = len_c;
      else if (rd_ok) rem_d = rem_q - need_c;
      udf_d = udf_q | rd_bad;
    end
  end

  assign upd = soft_rst | load | rd | push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      rem_q    <= '0;
      udf_q    <= 1'b0;
    end else if (upd) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      rem_q    <= rem_d;
      udf_q    <= udf_d;
    end
  end

  // Byte storage, one slot written per pushed byte
  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic              we;
    logic [LANE_W-1:0] byte_q;
    assign we = push_ok && (wr_ptr_q == PW'(j));
    always_ff @(posedge clk) begin
      if (we) byte_q <= din;
    end
    assign slots[j] = byte_q;
  end

  // Gather the oldest bytes into lanes, zero past the remaining count
  for (genvar k = 0; k < LANES; k++) begin : g_gather
    logic [PW-1:0] idx;
    assign idx    = rd_ptr_q + PW'(k);
    assign raw[k] = (rd_ok && (CW'(k) < need_c)) ? slots[idx] : '0;
  end

  spwf_lane_order u_order (
    .swap (swap),
    .din  (raw),
    .dout (rdata)
  );

  assign level = cnt_q;
  assign udf   = udf_q;

  // R10
  rx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R9
  rx_soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cnt_q == '0) && (rem_q == '0) && !udf_q);
  // R8
  rx_udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    udf_q && !soft_rst |=> udf_q);
  // R8
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && (need_c == '0) && !soft_rst |=> udf_q);
  // R6
  rx_pop_amount_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok && !push && !soft_rst |=> cnt_q == $past(cnt_q) - $past(need_c));
endmodule

// File: rtl/spi_word_fifo.sv
module spi_word_fifo
  import spwf_pkg::*;
#(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              chunk_load,
  input  logic [CW-1:0]     chunk_len,
  input  logic              tx_swap,
  input  logic              rx_swap,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              eng_tx_pop,
  output logic [LANE_W-1:0] eng_tx_byte,
  output logic [CW-1:0]     eng_tx_level,
  input  logic              eng_rx_push,
  input  logic [LANE_W-1:0] eng_rx_byte,
  output logic [CW-1:0]     eng_rx_level,
  output logic              tx_ovf,
  output logic              rx_udf
);
  logic       rst_meta_q, rst_sync_q;
  lane_word_t wdata_w, rdata_w;

  // Assert asynchronously, release on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign wdata_w    = host_wdata;
  assign host_rdata = rdata_w;

  spwf_tx_unpack #(.DEPTH(DEPTH)) u_tx (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .soft_rst (soft_rst),
    .load     (chunk_load),
    .len      (chunk_len),
    .swap     (tx_swap),
    .wr       (host_wr),
    .wdata    (wdata_w),
    .pop      (eng_tx_pop),
    .head     (eng_tx_byte),
    .level    (eng_tx_level),
    .ovf      (tx_ovf)
  );

  spwf_rx_pack #(.DEPTH(DEPTH)) u_rx (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .soft_rst (soft_rst),
    .load     (chunk_load),
    .len      (chunk_len),
    .swap     (rx_swap),
    .rd       (host_rd),
    .rdata    (rdata_w),
    .push     (eng_rx_push),
    .din      (eng_rx_byte),
    .level    (eng_rx_level),
    .udf      (rx_udf)
  );
endmodule

// File: tb/test_spi_word_fifo.sv
`timescale 1ns/1ps
module test_spi_word_fifo;
  typedef struct packed {
    logic [5:0]  len;
    logic        swap;
    logic [31:0] word;
    logic [31:0] exp;
    logic [2:0]  n;
  } vec_t;

  // chunk length, tx_swap, host word, expected bytes (first in [7:0]), count
  localparam logic [73:0] VEC [7] = '{
    {6'd8,  1'b0, 32'h44332211, 32'h44332211, 3'd4},
    {6'd4,  1'b1, 32'hA1B2C3D4, 32'hD4C3B2A1, 3'd4},
    {6'd3,  1'b0, 32'hFF665544, 32'h00665544, 3'd3},
    {6'd2,  1'b1, 32'h7788FFFF, 32'h00008877, 3'd2},
    {6'd1,  1'b0, 32'hEEEEEE5A, 32'h0000005A, 3'd1},
    {6'd0,  1'b0, 32'h12345678, 32'h00000000, 3'd0},
    {6'd40, 1'b0, 32'h04030201, 32'h04030201, 3'd4}
  };

  logic        clk, rst_n, soft_rst, chunk_load, tx_swap, rx_swap;
  logic [5:0]  chunk_len;
  logic        host_wr, host_rd, eng_tx_pop, eng_rx_push;
  logic [31:0] host_wdata, host_rdata;
  logic [7:0]  eng_tx_byte, eng_rx_byte;
  logic [5:0]  eng_tx_level, eng_rx_level;
  logic        tx_ovf, rx_udf;
  int          n_chk, n_fail;

  spi_word_fifo i_spi_word_fifo (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .chunk_load   (chunk_load),
    .chunk_len    (chunk_len),
    .tx_swap      (tx_swap),
    .rx_swap      (rx_swap),
    .host_wr      (host_wr),
    .host_wdata   (host_wdata),
    .host_rd      (host_rd),
    .host_rdata   (host_rdata),
    .eng_tx_pop   (eng_tx_pop),
    .eng_tx_byte  (eng_tx_byte),
    .eng_tx_level (eng_tx_level),
    .eng_rx_push  (eng_rx_push),
    .eng_rx_byte  (eng_rx_byte),
    .eng_rx_level (eng_rx_level),
    .tx_ovf       (tx_ovf),
    .rx_udf       (rx_udf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic srst();
    soft_rst = 1'b1; step(); soft_rst = 1'b0;
  endtask

  task automatic load(input logic [5:0] n);
    chunk_load = 1'b1; chunk_len = n; step(); chunk_load = 1'b0;
  endtask

  task automatic hwrite(input logic [31:0] w);
    host_wr = 1'b1; host_wdata = w; step(); host_wr = 1'b0;
  endtask

  task automatic tpop();
    eng_tx_pop = 1'b1; step(); eng_tx_pop = 1'b0;
  endtask

  task automatic rpush(input logic [7:0] b);
    eng_rx_push = 1'b1; eng_rx_byte = b; step(); eng_rx_push = 1'b0;
  endtask

  task automatic hread(input string req, input logic [31:0] exp);
    host_rd = 1'b1; #1; chk(req, host_rdata, exp); step(); host_rd = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; soft_rst = 1'b0; chunk_load = 1'b0; chunk_len = '0;
    tx_swap = 1'b0; rx_swap = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = '0; eng_tx_pop = 1'b0; eng_rx_push = 1'b0; eng_rx_byte = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 tx level", 32'(eng_tx_level), 0);
    chk("R1 rx level", 32'(eng_rx_level), 0);
    chk("R1 tx_ovf", 32'(tx_ovf), 0);
    chk("R1 rx_udf", 32'(rx_udf), 0);
    // R8 read with remaining count 0
    hread("R8 empty read data", 0);
    chk("R8 udf set", 32'(rx_udf), 1);
    srst();
    chk("R9 udf cleared", 32'(rx_udf), 0);

    // Vector table: TX unpack orders and partial words (R2 R3 R4)
    for (int i = 0; i < 7; i++) begin
      vec_t  v;
      string tag;
      v   = vec_t'(VEC[i]);
      tag = v.swap ? "R3" : ((v.n < 3'd4) ? "R4" : "R2");
      srst();
      load(v.len);
      tx_swap = v.swap;
      hwrite(v.word);
      tx_swap = 1'b0;
      chk("R4 stored count", 32'(eng_tx_level), 32'(v.n));
      chk("R4 no overflow", 32'(tx_ovf), 0);
      for (int b = 0; b < int'(v.n); b++) begin
        chk(tag, 32'(eng_tx_byte), 32'(v.exp[8*b +: 8]));
        tpop();
      end
      chk("R4 drained", 32'(eng_tx_level), 0);
    end

    // R11 wrap and R5 overflow
    srst();
    load(6'd3);
    hwrite(32'h00FFFFFF);
    repeat (3) tpop();
    load(6'd32);
    for (int k = 0; k < 8; k++)
      hwrite({8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    chk("R11 full level", 32'(eng_tx_level), 32);
    load(6'd32);
    hwrite(32'hDEADBEEF);
    chk("R5 ovf set", 32'(tx_ovf), 1);
    chk("R5 level held", 32'(eng_tx_level), 32);
    step();
    chk("R5 ovf sticky", 32'(tx_ovf), 1);
    for (int j = 0; j < 32; j++) begin
      chk("R11 order", 32'(eng_tx_byte), 32'(j));
      tpop();
    end
    chk("R10 tx empty", 32'(eng_tx_level), 0);
    tpop();
    chk("R10 pop on empty", 32'(eng_tx_level), 0);
    srst();
    chk("R9 ovf cleared", 32'(tx_ovf), 0);

    // R12 write and pop together
    srst();
    load(6'd8);
    hwrite(32'h03020100);
    host_wr = 1'b1; host_wdata = 32'h07060504; eng_tx_pop = 1'b1;
    #1;
    chk("R12 head before", 32'(eng_tx_byte), 32'h00);
    step();
    host_wr = 1'b0; eng_tx_pop = 1'b0;
    chk("R12 level", 32'(eng_tx_level), 7);
    chk("R12 next head", 32'(eng_tx_byte), 32'h01);

    // R6 packing with partial last word
    srst();
    load(6'd6);
    for (int b = 0; b < 6; b++) rpush(8'(8'h10 + b));
    chk("R6 rx level", 32'(eng_rx_level), 6);
    hread("R6 full word", 32'h13121110);
    chk("R6 level after", 32'(eng_rx_level), 2);
    hread("R6 partial word", 32'h00001514);
    chk("R6 drained", 32'(eng_rx_level), 0);

    // R7 swapped packing
    srst();
    load(6'd3);
    rpush(8'hAA); rpush(8'hBB); rpush(8'hCC);
    rx_swap = 1'b1;
    hread("R7 swapped word", 32'hAABBCC00);
    rx_swap = 1'b0;
    chk("R7 drained", 32'(eng_rx_level), 0);

    // R8 underflow with bytes short
    srst();
    load(6'd4);
    rpush(8'h01); rpush(8'h02);
    hread("R8 short read data", 0);
    chk("R8 udf set", 32'(rx_udf), 1);
    chk("R8 nothing removed", 32'(eng_rx_level), 2);
    srst();
    chk("R9 rx level", 32'(eng_rx_level), 0);
    chk("R9 udf cleared", 32'(rx_udf), 0);
    rpush(8'h55);
    hread("R9 remaining cleared", 0);
    chk("R9 remaining cleared udf", 32'(rx_udf), 1);

    // R10 push into full RX queue, then drain
    srst();
    load(6'd40);
    for (int b = 0; b < 33; b++) rpush(8'(b));
    chk("R10 rx full", 32'(eng_rx_level), 32);
    for (int k = 0; k < 8; k++)
      hread("R10 drain order", {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    chk("R10 rx drained", 32'(eng_rx_level), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule